// File: doc/BRIEF.md
# In-Order FP Completion Controller

This block is the control for a statically scheduled pipeline in which decode sends floating-point operations to one of two non-pipelined execution units. One unit handles add and subtract; the other handles multiply and divide. Each unit is modelled by an occupancy timer that runs for that unit's fixed latency. Decode is held when the unit it needs is still occupied, or when no completion slot is free.

Every accepted operation takes a slot in an in-order completion queue. The slot records the unit class, the destination register and a tag. A unit that finishes may be ahead of an older operation on the other unit. In that case its result is counted as finished and held until its slot reaches the queue head, so FP results are written back strictly in issue order, at most one per cycle.

The integer write-back enable is a separate path. It passes through in the same cycle whatever the FP side is doing, because the two register files are separate. The arithmetic datapaths and the register files are outside this block.

Top module: `fp_inorder_wb_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dec_stall`, `unit_start`, `unit_done` and `fp_wb_en` are all 0. A reset during activity frees both units and discards all queued operations, so none of them is ever written back.
- R2: Class encoding: `dec_cls` 0 selects the add/subtract unit and 1 selects the multiply/divide unit. `unit_start` bit 0 is the add unit and bit 1 is the multiply unit. A request with `dec_valid` high, a free target unit and a queue that is not full is accepted in the same cycle: `dec_stall` is 0 and the matching `unit_start` bit is 1.
- R3: A unit's `unit_done` bit pulses for one cycle, exactly ADD_LAT cycles (add unit) or MUL_LAT cycles (multiply unit) after the cycle in which that unit started.
- R4: A unit is occupied from the cycle after its start up to and including its done cycle. A request for an occupied unit raises `dec_stall` and starts nothing.
- R5: When an operation is at the queue head, its result is written back in the cycle after its done pulse. `fp_wb_en` is 1 and `fp_wb_dst`/`fp_wb_tag` carry the destination and tag given at issue.
- R6: Results are written back in issue order. A younger operation that finishes before an older one on the other unit waits until the older one has been written back.
- R7: When Q_DEPTH operations are outstanding (accepted but not yet written back), every request stalls, even if its unit is free. This includes the cycle in which the head is being written back.
- R8: At most one FP write-back occurs per cycle. `fp_wb_en` is never 1 with no operation outstanding.
- R9: `int_wb_en` equals `int_wb_req` in every cycle, including cycles with an FP write-back.
- R10: `dec_stall` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode presents an FP operation |
| dec_cls | input | 1 | Unit class: 0 add/subtract, 1 multiply/divide |
| dec_dst | input | DST_W | Destination FP register of the operation |
| dec_tag | input | TAG_W | Tag carried to write-back |
| int_wb_req | input | 1 | Integer pipeline wants to write its register file |
| dec_stall | output | 1 | Hold decode this cycle |
| unit_start | output | 2 | Start pulse per unit (bit 0 add, bit 1 multiply) |
| unit_done | output | 2 | Finish pulse per unit |
| fp_wb_en | output | 1 | FP register-file write enable |
| fp_wb_dst | output | DST_W | FP write-back destination |
| fp_wb_tag | output | TAG_W | FP write-back tag |
| int_wb_en | output | 1 | Integer register-file write enable |

## Verification
The hardest situation to reach is a full completion queue while the requested unit is free. With two non-pipelined units, the queue fills only when a long multiply sits at the head while the add unit completes one result that is held and then starts another.

The stimulus builds this case. It issues a multiply, then an add, retries a second add until the add unit frees, and then requests another multiply in the same cycle that the first multiply is being written back. That request must still stall.

The same sequence also produces the out-of-order finish that R6 needs: an add result is held behind the older multiply. It also lines an FP write-back up with an integer write-back request in the same cycle.

// File: rtl/fpwb_pkg.sv
// Package: shared unit-class encoding for the FP completion controller.
// Assumes exactly two FP units, indexed by the class value.
package fpwb_pkg;
    typedef enum logic {
        FU_ADD = 1'b0,
        FU_MUL = 1'b1
    } fu_cls_e;

    localparam int NUM_FU = 2;
endpackage

// File: rtl/fpwb_unit_timer.sv
// Occupancy timer for one non-pipelined FP unit.
// On start it loads LAT. It is busy while the count is non-zero and flags
// done in the last busy cycle. Assumes LAT >= 2 and that start is only
// asserted while the unit is not busy.
module fpwb_unit_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAT_V = CW'(LAT);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= LAT_V;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Busy and done decode from the count.
    always_comb begin
        busy = (cnt != '0);
        done = (cnt == CW'(1));
    end
endmodule

// File: rtl/fpwb_order_queue.sv
// Circular FIFO that holds issued FP operations in issue order.
// Assumes the user never pushes when full or pops when empty.
// DEPTH need not be a power of two.
module fpwb_order_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Store the pushed entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    // Advance the pointers with wrap and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Head view and occupancy flags.
    always_comb begin
        head_data = mem[rd_ptr];
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
    end
endmodule

// File: rtl/fp_inorder_wb_ctrl.sv
// In-order FP completion controller.
// Accepts decoded FP operations for two non-pipelined units and stalls
// decode on unit occupancy or a full completion queue. Finished results
// are counted per unit and written back only when their entry is at the
// queue head. The integer write-back path is independent.
// Assumes results of one unit finish in that unit's issue order, which
// holds because each unit runs one operation at a time.
module fp_inorder_wb_ctrl
    import fpwb_pkg::*;
#(
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 7,
    parameter int Q_DEPTH = 4,
    parameter int DST_W   = 5,
    parameter int TAG_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic             dec_cls,
    input  logic [DST_W-1:0] dec_dst,
    input  logic [TAG_W-1:0] dec_tag,
    input  logic             int_wb_req,
    output logic             dec_stall,
    output logic [1:0]       unit_start,
    output logic [1:0]       unit_done,
    output logic             fp_wb_en,
    output logic [DST_W-1:0] fp_wb_dst,
    output logic [TAG_W-1:0] fp_wb_tag,
    output logic             int_wb_en
);
    localparam int ENT_W = 1 + DST_W + TAG_W;
    localparam int RC_W  = $clog2(Q_DEPTH + 1);

    logic [NUM_FU-1:0] unit_busy;
    logic [ENT_W-1:0]  head_ent;
    logic              q_full, q_empty;
    logic              issue, pop;
    fu_cls_e           req_cls, head_cls;
    logic [RC_W-1:0]   rdy_cnt [NUM_FU];

    // Decode-side acceptance and per-unit start pulses.
    always_comb begin
        req_cls   = fu_cls_e'(dec_cls);
        dec_stall = dec_valid && (unit_busy[req_cls] || q_full);
        issue     = dec_valid && !dec_stall;
        unit_start[FU_ADD] = issue && (req_cls == FU_ADD);
        unit_start[FU_MUL] = issue && (req_cls == FU_MUL);
    end

    // One timer and one finished-result counter per unit.
    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        localparam int LAT_U = (u == 0) ? ADD_LAT : MUL_LAT;
        logic pop_u;

        fpwb_unit_timer #(.LAT(LAT_U)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .start (unit_start[u]),
            .busy  (unit_busy[u]),
            .done  (unit_done[u])
        );

        assign pop_u = pop && (head_cls == fu_cls_e'(u));

        // Count results that finished but are not yet written back.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdy_cnt[u] <= '0;
            else
                rdy_cnt[u] <= rdy_cnt[u] + RC_W'(unit_done[u]) - RC_W'(pop_u);
        end
    end

    fpwb_order_queue #(.DEPTH(Q_DEPTH), .W(ENT_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (issue),
        .push_data ({dec_cls, dec_dst, dec_tag}),
        .pop       (pop),
        .head_data (head_ent),
        .full      (q_full),
        .empty     (q_empty)
    );

    // Retire the head entry once its unit has a finished result waiting.
    always_comb begin
        head_cls  = fu_cls_e'(head_ent[ENT_W-1]);
        pop       = !q_empty && (rdy_cnt[head_cls] != '0);
        fp_wb_en  = pop;
        fp_wb_dst = pop ? head_ent[TAG_W +: DST_W] : '0;
        fp_wb_tag = pop ? head_ent[TAG_W-1:0] : '0;
    end

    // Integer write-back runs beside the FP path.
    assign int_wb_en = int_wb_req;
endmodule

// File: rtl/fpwb_chk.sv
// Checker for the FP completion controller.
// It keeps its own latency count per unit and its own count of
// outstanding operations, and checks the ports against them.
module fpwb_chk #(
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 7,
    parameter int Q_DEPTH = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_valid,
    input logic       dec_cls,
    input logic       int_wb_req,
    input logic       dec_stall,
    input logic [1:0] unit_start,
    input logic [1:0] unit_done,
    input logic       fp_wb_en,
    input logic       int_wb_en
);
    localparam int MAXL = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int RW   = $clog2(MAXL + 1);
    localparam int OW   = $clog2(Q_DEPTH + 1) + 1;

    logic [OW-1:0] outst;

    // Outstanding operations: accepted minus written back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outst <= '0;
        else
            outst <= outst + OW'(|unit_start) - OW'(fp_wb_en);
    end

    for (genvar u = 0; u < 2; u++) begin : g_lat
        localparam int LU = (u == 0) ? ADD_LAT : MUL_LAT;
        logic [RW-1:0] rem;

        // Cycles left until this unit's expected finish.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rem <= '0;
            else if (unit_start[u])
                rem <= RW'(LU);
            else if (rem != '0)
                rem <= rem - 1'b1;
        end

        // R3
        done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            unit_done[u] == (rem == RW'(1)));

        // R4
        no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            unit_start[u] |=> !unit_start[u]);
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_start) |-> (dec_valid && !dec_stall && (unit_start[1] == dec_cls)));

    // R2
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_start));

    // R7
    queue_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= OW'(Q_DEPTH));

    // R8
    wb_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp_wb_en |-> (outst != '0));

    // R9
    int_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_wb_en == int_wb_req);

    // R10
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |-> dec_valid);
endmodule

bind fp_inorder_wb_ctrl fpwb_chk #(
    .ADD_LAT (ADD_LAT),
    .MUL_LAT (MUL_LAT),
    .Q_DEPTH (Q_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_cls    (dec_cls),
    .int_wb_req (int_wb_req),
    .dec_stall  (dec_stall),
    .unit_start (unit_start),
    .unit_done  (unit_done),
    .fp_wb_en   (fp_wb_en),
    .int_wb_en  (int_wb_en)
);

// File: tb/fp_inorder_wb_ctrl_tb.sv
module fp_inorder_wb_ctrl_tb;
    localparam int NV = 18;
    // {vld, cls, dst[5], ireq, e_stall, e_start[2], e_done[2], e_wb, e_wdst[5]}
    localparam logic [18:0] TBL [NV] = '{
        {1'b1, 1'b1, 5'd1, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0, 5'd0}, // c0 mul issue (R2)
        {1'b1, 1'b0, 5'd2, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 5'd0}, // c1 add issue
        {1'b1, 1'b0, 5'd3, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0}, // c2 add busy (R4)
        {1'b1, 1'b1, 5'd4, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0}, // c3 mul busy
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0}, // c4 idle (R10)
        {1'b1, 1'b0, 5'd3, 1'b0, 1'b1, 2'b00, 2'b01, 1'b0, 5'd0}, // c5 add done, still busy
        {1'b1, 1'b0, 5'd3, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 5'd0}, // c6 add held (R6), queue full
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0, 5'd0}, // c7 mul done
        {1'b1, 1'b1, 5'd5, 1'b0, 1'b1, 2'b00, 2'b00, 1'b1, 5'd1}, // c8 full stall (R7), wb mul
        {1'b1, 1'b1, 5'd5, 1'b1, 1'b0, 2'b10, 2'b00, 1'b1, 5'd2}, // c9 held add wb + int (R9)
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b01, 1'b0, 5'd0}, // c10
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 5'd3}, // c11
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0},
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0},
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0},
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0},
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0, 5'd0}, // c16 mul done
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 5'd5}  // c17
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0, dec_cls = 1'b0, int_wb_req = 1'b0;
    logic [4:0] dec_dst = '0;
    logic [3:0] dec_tag;
    logic       dec_stall, fp_wb_en, int_wb_en;
    logic [1:0] unit_start, unit_done;
    logic [4:0] fp_wb_dst;
    logic [3:0] fp_wb_tag;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    assign dec_tag = dec_dst[3:0] ^ 4'hA;

    always #2 clk = ~clk;

    fp_inorder_wb_ctrl #(.ADD_LAT(4), .MUL_LAT(7), .Q_DEPTH(3), .DST_W(5), .TAG_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
        .dec_dst(dec_dst), .dec_tag(dec_tag), .int_wb_req(int_wb_req),
        .dec_stall(dec_stall), .unit_start(unit_start), .unit_done(unit_done),
        .fp_wb_en(fp_wb_en), .fp_wb_dst(fp_wb_dst), .fp_wb_tag(fp_wb_tag),
        .int_wb_en(int_wb_en)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk({tag, " stall"}, dec_stall, 0);
        chk({tag, " start"}, unit_start, 0);
        chk({tag, " done"}, unit_done, 0);
        chk({tag, " wb"}, fp_wb_en, 0);
    endtask

    initial begin
        #(4 * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int wbs;
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        #1 chk_quiet("R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        #1 chk_quiet("R1 after release");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {dec_valid, dec_cls, dec_dst, int_wb_req} = TBL[i][18:11];
            #1;
            chk($sformatf("R4/R7/R10 stall c%0d", i), dec_stall, TBL[i][10]);
            chk($sformatf("R2 start c%0d", i), unit_start, TBL[i][9:8]);
            chk($sformatf("R3 done c%0d", i), unit_done, TBL[i][7:6]);
            chk($sformatf("R5/R8 wb_en c%0d", i), fp_wb_en, TBL[i][5]);
            if (TBL[i][5]) begin
                chk($sformatf("R6 wb_dst c%0d", i), fp_wb_dst, TBL[i][4:0]);
                chk($sformatf("R5 wb_tag c%0d", i), fp_wb_tag, TBL[i][3:0] ^ 4'hA);
            end
            chk($sformatf("R9 int_wb c%0d", i), int_wb_en, TBL[i][11]);
        end

        // R1: reset during a multiply discards it and frees the unit
        @(negedge clk);
        {dec_valid, dec_cls, dec_dst, int_wb_req} = {1'b1, 1'b1, 5'd6, 1'b0};
        @(negedge clk);
        dec_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 chk_quiet("R1 mid-run reset");
        @(negedge clk);
        {dec_valid, dec_cls, dec_dst} = {1'b1, 1'b1, 5'd7};
        #1;
        chk("R1 unit freed stall", dec_stall, 0);
        chk("R1 unit freed start", unit_start, 2'b10);
        wbs = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            dec_valid = 1'b0;
            #1;
            if (fp_wb_en) begin
                wbs++;
                chk("R1 only new op written", fp_wb_dst, 7);
                chk("R5 wb cycle after reset", k, 8);
            end
        end
        chk("R1 single wb after reset", wbs, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule